// File: doc/BRIEF.md
# Program Counter Steering Unit with Condition Code and Link

This block owns the program counter of a processor with 24-bit addresses. Every cycle on which the issue strobe is high, it takes the opcode byte, the address already computed for the instruction, the instruction's byte length and the execution side's compare result. It then picks the next program counter. The choices are: fall through to the next sequential instruction, jump unconditionally, jump on one of three condition-code tests, call a subroutine, or return from one.

Subroutine linkage uses one register and no stack. A call overwrites that register with its return address, and a return reads it back. The block also holds the 2-bit condition code. Four compare-type opcodes update it, one of which is the fused increment-index-and-compare. The branch tests read it.

The issue interface carries only a valid strobe. The block takes an instruction on every cycle the strobe is high and never applies back-pressure. An upstream stage may present a new instruction on every clock. The program counter, link register, condition code and branch flag are registered outputs. Each one shows the effect of an issued instruction on the cycle after that instruction.

Top module: `pc_steer_unit`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the outputs are as follows: `pc` equals the parameter `START_PC` (default 0x000100), `cc` is 01 (equal), `link` is zero and `br_taken` is low.
- R2: On a cycle with `op_valid` low, `pc`, `link` and `cc` keep their values and `br_taken` is low on the next cycle, whatever the other inputs carry.
- R3: The sequential address is `pc + len_code + 1`, because `len_code` 0..3 encodes 1..4 bytes. It is computed modulo 2^24. Any opcode that is not a flow opcode moves `pc` to this address.
- R4: An opcode whose upper six bits are 0x3C>>2 (bytes 0x3C..0x3F) loads `pc` with `target`.
- R5: Bytes 0x30..0x33 jump to `target` when `cc` is 01. Bytes 0x34..0x37 jump when `cc` is 10. Bytes 0x38..0x3B jump when `cc` is 00. When its test fails, each of them falls through to the sequential address.
- R6: Bytes 0x48..0x4B write the sequential address into `link` and load `pc` with `target`.
- R7: Bytes 0x4C..0x4F load `pc` from `link` and leave `link` unchanged.
- R8: Bytes 0x28..0x2F and the exact bytes 0xA0 and 0xB8 copy `cmp_res` into `cc`. The encoding is less = 00, equal = 01, greater = 10. The reserved code 11 leaves `cc` unchanged, so `cc` never reads 11.
- R9: Every other opcode leaves `cc` unchanged. This includes 0xA1 and 0xB9, because the format-2 compares match all eight bits.
- R10: `br_taken` is high for exactly the one cycle after an issued instruction whose new `pc` differs from its sequential address. A jump whose target equals the sequential address does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Issue strobe, one instruction per high cycle |
| opcode | input | 8 | Opcode byte of the issued instruction |
| target | input | 24 | Effective target address |
| len_code | input | 2 | Instruction length minus one, in bytes |
| cmp_res | input | 2 | Compare outcome: 00 less, 01 equal, 10 greater, 11 reserved |
| pc | output | 24 | Current program counter |
| link | output | 24 | Return address register |
| cc | output | 2 | Condition code |
| br_taken | output | 1 | Flow left the sequential path last cycle |

## Verification
The bench focuses on the places where a decoder would plausibly go wrong:
- It sends flag-bit variants of the memory-format opcodes (0x3F, 0x37, 0x2D, 0x4F). A unit that matched all eight bits would fall through on them instead of jumping or comparing.
- It sends near-miss register-format bytes (0xA1, 0xB9). A unit that masked those bits would corrupt the condition code.
- It sends the reserved compare code. A unit that copied it would leave `cc` at 11, where no branch test is true.
- It runs the address past 0xFFFFFF. A missing modulo would show up as a wrong fall-through value.
- It issues a call followed by a return. A unit that saved the pre-increment address, or clobbered the link register on return, would come back one instruction early or somewhere else.
- It issues a jump whose target is the sequential address. A unit that raised `br_taken` on every jump opcode would flag it.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;

  // upper six bits of memory-format opcodes (low two bits are addressing flags)
  localparam logic [5:0] OP6_JMP  = 6'h0F;
  localparam logic [5:0] OP6_CALL = 6'h12;
  localparam logic [5:0] OP6_RET  = 6'h13;
  localparam logic [5:0] OP6_CMPM = 6'h0A;
  localparam logic [5:0] OP6_CIXM = 6'h0B;

  // register-format compares match all eight bits
  localparam logic [7:0] OP8_CMPR = 8'hA0;
  localparam logic [7:0] OP8_CIXR = 8'hB8;

  // condition code values
  localparam logic [1:0] CC_LT  = 2'b00;
  localparam logic [1:0] CC_EQ  = 2'b01;
  localparam logic [1:0] CC_GT  = 2'b10;
  localparam logic [1:0] CC_RSV = 2'b11;

  // conditional jumps: entry i jumps when cc equals COND_CC[i]
  localparam int NCOND = 3;
  localparam logic [5:0] COND_OP6 [NCOND] = '{6'h0C, 6'h0D, 6'h0E};
  localparam logic [1:0] COND_CC  [NCOND] = '{CC_EQ, CC_GT, CC_LT};

  typedef struct packed {
    logic             is_jmp;
    logic             is_call;
    logic             is_ret;
    logic [NCOND-1:0] cond_hit;
    logic             is_cmp;
  } op_class_t;

endpackage

// File: rtl/pc_op_decode.sv
module pc_op_decode
  import pc_steer_pkg::*;
(
  input  logic [7:0] opcode,
  output op_class_t  cls
);

  logic [5:0]       op6;
  logic [NCOND-1:0] cond_w;

  assign op6 = opcode[7:2];

  for (genvar i = 0; i < NCOND; i++) begin : g_cond
    assign cond_w[i] = (op6 == COND_OP6[i]);
  end

  always_comb begin
    cls          = '0;
    cls.is_jmp   = (op6 == OP6_JMP);
    cls.is_call  = (op6 == OP6_CALL);
    cls.is_ret   = (op6 == OP6_RET);
    cls.cond_hit = cond_w;
    cls.is_cmp   = (op6 == OP6_CMPM) || (op6 == OP6_CIXM) ||
                   (opcode == OP8_CMPR) || (opcode == OP8_CIXR);
  end

endmodule

// File: rtl/pc_cc_keeper.sv
module pc_cc_keeper
  import pc_steer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  logic [1:0] cmp_res,
  output logic [1:0] cc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc <= CC_EQ;
    end else if (upd && (cmp_res != CC_RSV)) begin
      cc <= cmp_res;
    end
  end

endmodule

// File: rtl/pc_next_sel.sv
module pc_next_sel
  import pc_steer_pkg::*;
#(
  parameter int AW = 24
) (
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] cur_link,
  input  logic [AW-1:0] target,
  input  logic [1:0]    len_code,
  input  logic [1:0]    cc,
  input  op_class_t     cls,
  output logic [AW-1:0] seq_pc,
  output logic [AW-1:0] nxt_pc,
  output logic          leave_seq
);

  logic [NCOND-1:0] cond_pass;
  logic             cond_go;

  assign seq_pc = cur_pc + AW'(len_code) + AW'(1);

  for (genvar i = 0; i < NCOND; i++) begin : g_test
    assign cond_pass[i] = cls.cond_hit[i] && (cc == COND_CC[i]);
  end

  assign cond_go = |cond_pass;

  always_comb begin
    if (cls.is_ret) begin
      nxt_pc = cur_link;
    end else if (cls.is_jmp || cls.is_call || cond_go) begin
      nxt_pc = target;
    end else begin
      nxt_pc = seq_pc;
    end
  end

  assign leave_seq = (nxt_pc != seq_pc);

endmodule

// File: rtl/pc_steer_unit.sv
module pc_steer_unit
  import pc_steer_pkg::*;
#(
  parameter int            AW       = 24,
  parameter logic [AW-1:0] START_PC = 24'h000100
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [7:0]    opcode,
  input  logic [AW-1:0] target,
  input  logic [1:0]    len_code,
  input  logic [1:0]    cmp_res,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] link,
  output logic [1:0]    cc,
  output logic          br_taken
);

  op_class_t     cls;
  logic [AW-1:0] seq_pc;
  logic [AW-1:0] nxt_pc;
  logic          leave_seq;

  pc_op_decode u_dec (
    .opcode (opcode),
    .cls    (cls)
  );

  pc_cc_keeper u_cc (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd     (op_valid && cls.is_cmp),
    .cmp_res (cmp_res),
    .cc      (cc)
  );

  pc_next_sel #(.AW(AW)) u_sel (
    .cur_pc    (pc),
    .cur_link  (link),
    .target    (target),
    .len_code  (len_code),
    .cc        (cc),
    .cls       (cls),
    .seq_pc    (seq_pc),
    .nxt_pc    (nxt_pc),
    .leave_seq (leave_seq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= START_PC;
      link     <= '0;
      br_taken <= 1'b0;
    end else begin
      br_taken <= op_valid && leave_seq;
      if (op_valid) begin
        pc <= nxt_pc;
        if (cls.is_call) begin
          link <= seq_pc;
        end
      end
    end
  end

endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk #(
  parameter int AW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [7:0]    opcode,
  input logic [AW-1:0] target,
  input logic [1:0]    len_code,
  input logic [1:0]    cmp_res,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] link,
  input logic [1:0]    cc,
  input logic          br_taken
);

  logic [AW-1:0] seq_w;
  logic          cmp_w;

  assign seq_w = pc + AW'(len_code) + AW'(1);
  assign cmp_w = (opcode[7:2] == 6'h0A) || (opcode[7:2] == 6'h0B) ||
                 (opcode == 8'hA0) || (opcode == 8'hB8);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(pc) && $stable(link) && $stable(cc) && !br_taken));

  assert_jump_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[7:2] == 6'h0F) |=> (pc == $past(target)));

  assert_call_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[7:2] == 6'h12) |=> (pc == $past(target) && link == $past(seq_w)));

  assert_return_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && opcode[7:2] == 6'h13) |=> (pc == $past(link) && $stable(link)));

  assert_cc_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cc != 2'b11);

  assert_cc_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !cmp_w) |=> $stable(cc));

  assert_taken_R10: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (br_taken == (pc != $past(seq_w))));

endmodule

bind pc_steer_unit pc_steer_chk #(.AW(AW)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_valid (op_valid),
  .opcode   (opcode),
  .target   (target),
  .len_code (len_code),
  .cmp_res  (cmp_res),
  .pc       (pc),
  .link     (link),
  .cc       (cc),
  .br_taken (br_taken)
);

// File: tb/pc_steer_unit_tb_top.sv
`timescale 1ns/1ps
module pc_steer_unit_tb_top;

  localparam logic [23:0] START = 24'h000100;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [23:0] target = '0;
  logic [1:0]  len_code = '0;
  logic [1:0]  cmp_res = '0;
  logic [23:0] pc, link;
  logic [1:0]  cc;
  logic        br_taken;

  always #2.5 clk = ~clk;

  pc_steer_unit #(.AW(24), .START_PC(START)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .target(target), .len_code(len_code), .cmp_res(cmp_res),
    .pc(pc), .link(link), .cc(cc), .br_taken(br_taken)
  );

  typedef struct {
    logic [23:0] pc;
    logic [23:0] link;
    logic [1:0]  cc;
    logic        tk;
    string       tag;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [23:0] m_pc, m_link;
  logic [1:0]  m_cc;

  task automatic compare(input exp_t e);
    n_cmp++;
    if (pc !== e.pc || link !== e.link || cc !== e.cc || br_taken !== e.tk) begin
      n_bad++;
      $display("FAIL %s: pc %h exp %h, link %h exp %h, cc %b exp %b, taken %b exp %b",
               e.tag, pc, e.pc, link, e.link, cc, e.cc, br_taken, e.tk);
    end
  endtask

  // driver: apply one cycle of stimulus and push the modelled result
  task automatic issue(input logic v, input logic [7:0] op, input logic [23:0] tgt,
                       input logic [1:0] lc, input logic [1:0] cr, input string tag);
    logic [23:0] seq, npc, nlink;
    logic [1:0]  ncc;
    logic [5:0]  hi;
    exp_t e;
    @(negedge clk);
    op_valid = v; opcode = op; target = tgt; len_code = lc; cmp_res = cr;
    seq = m_pc + 24'(lc) + 24'd1;
    npc = m_pc; nlink = m_link; ncc = m_cc;
    hi = op[7:2];
    if (v) begin
      npc = seq;
      if (hi == 6'h0F) npc = tgt;
      if (hi == 6'h0C && m_cc == 2'b01) npc = tgt;
      if (hi == 6'h0D && m_cc == 2'b10) npc = tgt;
      if (hi == 6'h0E && m_cc == 2'b00) npc = tgt;
      if (hi == 6'h12) begin nlink = seq; npc = tgt; end
      if (hi == 6'h13) npc = m_link;
      if ((hi == 6'h0A || hi == 6'h0B || op == 8'hA0 || op == 8'hB8) && cr != 2'b11)
        ncc = cr;
    end
    e.pc = npc; e.link = nlink; e.cc = ncc;
    e.tk = v && (npc != seq);
    e.tag = tag;
    q.push_back(e);
    m_pc = npc; m_link = nlink; m_cc = ncc;
  endtask

  // monitor: one expected item per clock once stimulus starts
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not finish, pending %0d exp 0", q.size());
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    exp_t r;
    logic [7:0] ops [16] = '{8'h18, 8'h3C, 8'h3E, 8'h30, 8'h31, 8'h34, 8'h38, 8'h3A,
                             8'h48, 8'h4C, 8'h28, 8'h2C, 8'hA0, 8'hB8, 8'hA1, 8'h90};
    m_pc = START; m_link = '0; m_cc = 2'b01;
    r.pc = START; r.link = '0; r.cc = 2'b01; r.tk = 1'b0;

    // R1 during reset
    repeat (3) @(negedge clk);
    r.tag = "R1 in reset";
    compare(r);
    rst_n = 1'b1;
    @(posedge clk); #1;
    r.tag = "R1 after release";
    compare(r);

    issue(0, 8'h3C, 24'h777777, 2'd0, 2'd0, "R2 idle with jump opcode");
    issue(1, 8'h18, 24'h123456, 2'd0, 2'd2, "R3 length 1");
    issue(1, 8'h18, 24'h123456, 2'd1, 2'd2, "R3 length 2");
    issue(1, 8'h18, 24'h123456, 2'd2, 2'd2, "R3 length 3");
    issue(1, 8'h18, 24'h123456, 2'd3, 2'd2, "R3 length 4");
    issue(1, 8'h3C, 24'h000400, 2'd2, 2'd0, "R4 jump");
    issue(1, 8'h3F, 24'h000800, 2'd2, 2'd0, "R4 jump flag bits");
    issue(1, 8'hA1, 24'h0, 2'd1, 2'd2, "R9 near compare 0xA1");
    issue(1, 8'h30, 24'h000900, 2'd2, 2'd0, "R5 equal jump taken");
    issue(1, 8'h34, 24'h000A00, 2'd2, 2'd0, "R5 greater jump falls");
    issue(1, 8'h28, 24'h0, 2'd2, 2'd0, "R8 compare less");
    issue(1, 8'h38, 24'h000B00, 2'd2, 2'd0, "R5 less jump taken");
    issue(1, 8'h30, 24'h000C00, 2'd2, 2'd0, "R5 equal jump falls");
    issue(1, 8'h2D, 24'h0, 2'd2, 2'd2, "R8 index compare greater");
    issue(1, 8'h37, 24'h000D00, 2'd2, 2'd0, "R5 greater jump flag bits");
    issue(1, 8'hB8, 24'h0, 2'd1, 2'd3, "R8 reserved code ignored");
    issue(1, 8'hA0, 24'h0, 2'd1, 2'd1, "R8 register compare equal");
    issue(1, 8'h48, 24'h005000, 2'd2, 2'd0, "R6 call");
    issue(1, 8'h18, 24'h0, 2'd2, 2'd0, "R3 inside subroutine");
    issue(0, 8'h4C, 24'h0, 2'd0, 2'd0, "R2 idle with return opcode");
    issue(1, 8'h4F, 24'h0, 2'd2, 2'd0, "R7 return");
    issue(1, 8'h3C, m_pc + 24'd3, 2'd2, 2'd0, "R10 jump to sequential address");
    issue(1, 8'h3C, 24'hFFFFFE, 2'd2, 2'd0, "R4 jump near top");
    issue(1, 8'h18, 24'h0, 2'd3, 2'd0, "R3 wrap past top");
    issue(1, 8'hB9, 24'h0, 2'd1, 2'd0, "R9 near compare 0xB9");
    issue(1, 8'h4B, 24'h00F000, 2'd3, 2'd0, "R6 call flag bits");
    issue(1, 8'h4C, 24'h0, 2'd2, 2'd0, "R7 return to caller");

    for (int i = 0; i < 400; i++) begin
      logic v;
      v = ($urandom % 10) != 0;
      issue(v, ops[$urandom % 16], 24'($urandom), 2'($urandom), 2'($urandom),
            "R10 random mix");
    end
    issue(0, 8'h00, 24'h0, 2'd0, 2'd0, "R2 final idle");

    while (q.size() > 0) @(posedge clk);
    @(posedge clk); #2;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule